// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the system clock into a periodic one-cycle enable, one pulse per oversampled bit slot. It is meant to sit beside a serial transmitter and receiver, which use the pulse to advance their bit timing. The average period is a 16-bit integer divisor plus a 4-bit fraction counted in sixteenths of a clock. A small fractional accumulator lengthens some periods by one clock so that the average comes out right.

Software loads the integer divisor one byte at a time through a simple write port. A byte write counts only while the divisor-access input is high. Each accepted write restarts the period, so the new rate takes effect at a known point. The fraction arrives on its own input and is registered every cycle. When the divisor is zero the generator stops: no tick is produced and the running flag drops.

Top module: `frac_baud_gen`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge), `baud_tick` and `running` are low and the divisor is zero. A reset applied while the generator is running leaves it stopped, with no tick, until the divisor is written again.
- R2: While the divisor is zero, `running` is low and `baud_tick` stays low. `running` takes the value (divisor != 0) at the same rising edge that stores a write.
- R3: A write is accepted at a rising edge where both `wr_en` and `div_access` are high. `wr_sel` = 0 loads the low byte and `wr_sel` = 1 loads the high byte. The divisor is {high, low}. A write with `div_access` low changes neither the divisor nor the tick schedule.
- R4: Let the last accepted write be stored at edge E0, giving divisor D (nonzero). The accumulator is cleared by that write. No tick appears after edge E0+1, and the first tick is high after edge E0+D+1.
- R5: With the fraction F held constant, tick n (counting from 1) is high after edge E0 + D + 1 + (n-1)*D + floor((n-1)*F/16). Equivalently, each tick adds F to a 4-bit accumulator, and a carry out makes the following period D+1 clocks instead of D.
- R6: With D = 1 and F = 0, `baud_tick` is high on every cycle from edge E0+2 onward.
- R7: With D >= 2, every tick is high for exactly one clock cycle and comes from a register.
- R8: The fraction input is registered every cycle. A change to it affects the next tick's accumulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| div_access | input | 1 | Permits divisor byte writes when high |
| wr_en | input | 1 | Write strobe for a divisor byte |
| wr_sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_data | input | 8 | Byte value to write |
| frac_in | input | 4 | Fractional divisor in sixteenths |
| baud_tick | output | 1 | One-cycle registered baud enable |
| running | output | 1 | High while the divisor is nonzero |

## Verification
`running` changes at the same edge that stores a write. The first tick follows D+1 edges later, because the restart pulse and the tick each pass through one register. Every later tick is due D or D+1 edges after the previous one, as the R5 formula sets out. The bench sets its inputs at the falling edge and numbers each rising edge from the storing edge of the last write. It samples at the next falling edge and compares every cycle in the window with the formula, so a tick that arrives early, late, doubled or missing fails that cycle. For ignored writes and for a zero divisor, the check watches `running` and `baud_tick` for a fixed number of cycles after the stimulus.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    // Byte half addressed by the write port.
    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } div_half_e;
endpackage

// File: rtl/fbg_div_regs.sv
module fbg_div_regs
    import fbg_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                div_access_i,
    input  logic                wr_en_i,
    input  logic                wr_sel_i,
    input  logic [BYTE_W-1:0]   wr_data_i,
    input  logic [FRAC_W-1:0]   frac_i,
    output logic [2*BYTE_W-1:0] divisor_o,
    output logic [FRAC_W-1:0]   frac_o,
    output logic                restart_o,
    output logic                running_o
);
    localparam int DIV_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic [FRAC_W-1:0] frac;
        logic              restart;
        logic              running;
    } regs_t;

    regs_t     st_d, st_q;
    logic      accept;
    div_half_e half;

    always_comb begin
        st_d         = st_q;
        st_d.frac    = frac_i;
        st_d.restart = 1'b0;
        accept       = wr_en_i && div_access_i;
        half         = div_half_e'(wr_sel_i);
        if (accept) begin
            if (half == HALF_HIGH) begin
                st_d.hi = wr_data_i;
            end else begin
                st_d.lo = wr_data_i;
            end
            st_d.restart = 1'b1;
        end
        st_d.running = ({st_d.hi, st_d.lo} != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign divisor_o = {st_q.hi, st_q.lo};
    assign frac_o    = st_q.frac;
    assign restart_o = st_q.restart;
    assign running_o = st_q.running;

    // R3
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && div_access_i) |=> $stable(divisor_o));

    // R2
    stopped_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor_o == '0) |-> !running_o);

    logic [DIV_W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/fbg_tick_core.sv
module fbg_tick_core #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              restart_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
        logic              tick;
    } core_t;

    core_t             st_d, st_q;
    logic [FRAC_W:0]   sum;
    logic              carry;
    logic              active;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        sum       = {1'b0, st_q.acc} + {1'b0, frac_i};
        carry     = sum[FRAC_W];
        active    = (divisor_i != '0);
        if (restart_i) begin
            st_d.acc = '0;
            st_d.cnt = active ? (divisor_i - DIV_W'(1)) : '0;
        end else if (!active) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == '0) begin
            st_d.tick = 1'b1;
            st_d.acc  = sum[FRAC_W-1:0];
            st_d.cnt  = divisor_i - DIV_W'(1) + {{(DIV_W-1){1'b0}}, carry};
        end else begin
            st_d.cnt = st_q.cnt - DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    // R2
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor_i == '0) |=> !tick_o);

    // R4
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !tick_o);

    // R7
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && ($past(divisor_i) > DIV_W'(1))) |=> !tick_o);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_access,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [FRAC_W-1:0] frac_in,
    output logic              baud_tick,
    output logic              running
);
    localparam int DIV_W = 2 * BYTE_W;

    logic [DIV_W-1:0]  divisor;
    logic [FRAC_W-1:0] frac;
    logic              restart;

    fbg_div_regs #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .div_access_i (div_access),
        .wr_en_i      (wr_en),
        .wr_sel_i     (wr_sel),
        .wr_data_i    (wr_data),
        .frac_i       (frac_in),
        .divisor_o    (divisor),
        .frac_o       (frac),
        .restart_o    (restart),
        .running_o    (running)
    );

    fbg_tick_core #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .divisor_i (divisor),
        .frac_i    (frac),
        .restart_i (restart),
        .tick_o    (baud_tick)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!baud_tick && !running));
endmodule

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_access = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] frac_in = 4'h0;
    logic       baud_tick;
    logic       running;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    frac_baud_gen u_frac_baud_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_access (div_access),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .frac_in    (frac_in),
        .baud_tick  (baud_tick),
        .running    (running)
    );

    function automatic int exp_edge(int n, int d, int f);
        return d + 1 + (n - 1) * d + ((n - 1) * f) / 16;
    endfunction

    task automatic check(input string req, input bit ok, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_byte(input logic sel, input logic [7:0] data, input logic acc);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data; div_access = acc;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; div_access = 1'b0;
    endtask

    task automatic watch_quiet(input int ncyc, input string req, input string what);
        int hits = 0;
        for (int c = 1; c <= ncyc; c++) begin
            @(posedge clk); @(negedge clk);
            if (baud_tick !== 1'b0) hits++;
        end
        check(req, hits == 0, hits, 0, what);
    endtask

    task automatic run_sched(input int d, input int f, input int nt, input string req);
        int n = 1;
        int bad = 0;
        int bad_c = 0;
        int bad_v = 0;
        int limit;
        bit expb;
        @(negedge clk); frac_in = f[3:0];
        @(negedge clk);
        write_byte(1'b0, d[7:0], 1'b1);
        write_byte(1'b1, d[15:8], 1'b1);
        check(req, running === 1'b1, int'(running), 1, $sformatf("running after divisor %0d", d));
        limit = exp_edge(nt, d, f);
        for (int c = 1; c <= limit; c++) begin
            @(posedge clk); @(negedge clk);
            expb = (c == exp_edge(n, d, f));
            if (baud_tick !== expb) begin
                if (bad == 0) begin bad_c = c; bad_v = int'(baud_tick); end
                bad++;
            end
            if (expb) n++;
        end
        check(req, bad == 0, bad_v, int'(bad_v == 0),
              $sformatf("tick schedule D=%0d F=%0d first mismatch at edge %0d", d, f, bad_c));
    endtask

    task automatic measure_gaps(input int gap, input int count, input string req);
        int wait_c = 0;
        int bad = 0;
        int bad_g = 0;
        while (baud_tick !== 1'b1 && wait_c < 1000) begin
            @(posedge clk); @(negedge clk); wait_c++;
        end
        for (int k = 0; k < count; k++) begin
            int g = 0;
            do begin
                @(posedge clk); @(negedge clk); g++;
            end while (baud_tick !== 1'b1 && g < 1000);
            if (g != gap) begin bad++; bad_g = g; end
        end
        check(req, bad == 0 && wait_c < 1000, bad_g, gap, "tick spacing");
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", baud_tick === 1'b0, int'(baud_tick), 0, "tick after reset");
        check("R1", running === 1'b0, int'(running), 0, "running after reset");
        // R2 zero divisor is silent
        watch_quiet(100, "R2", "ticks with zero divisor");
        // R3 locked writes ignored
        write_byte(1'b0, 8'h05, 1'b0);
        write_byte(1'b1, 8'h01, 1'b0);
        check("R3", running === 1'b0, int'(running), 0, "running after locked writes");
        watch_quiet(100, "R3", "ticks after locked writes");
        // R6 divide by one
        run_sched(1, 0, 40, "R6");
        // R4 R5 directed schedules
        run_sched(5, 0, 12, "R4");
        run_sched(3, 8, 24, "R5");
        run_sched(2, 15, 34, "R5");
        run_sched(1, 8, 30, "R5");
        run_sched(256, 1, 17, "R5");
        run_sched(7, 4, 20, "R7");
        // R3 locked write mid-run leaves the period alone
        run_sched(4, 0, 3, "R4");
        write_byte(1'b0, 8'h00, 1'b0);
        write_byte(1'b1, 8'h09, 1'b0);
        check("R3", running === 1'b1, int'(running), 1, "running after locked zero write");
        measure_gaps(4, 6, "R3");
        // R2 accepted write of zero stops it
        write_byte(1'b0, 8'h00, 1'b1);
        check("R2", running === 1'b0, int'(running), 0, "running after zero write");
        watch_quiet(120, "R2", "ticks after zero write");
        // R8 fraction change takes effect
        run_sched(6, 12, 20, "R8");
        // R5 random schedules
        for (int i = 0; i < 8; i++) begin
            int d = 1 + int'($urandom_range(0, 39));
            int f = int'($urandom_range(0, 15));
            run_sched(d, f, 24, "R5");
        end
        // R1 reset while running
        run_sched(3, 0, 4, "R4");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1", running === 1'b0, int'(running), 0, "running after mid-run reset");
        watch_quiet(60, "R1", "ticks after mid-run reset");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule